// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

The block is a bank of general-purpose down-counters reached through a single-cycle register bus. A global switch and a per-channel switch must both be on for a channel to count; the channel then decrements once per clock. When it passes through zero it restarts from its programmed start value, bumps a wrap counter and raises a sticky interrupt flag. The flag reaches a pin only when the channel's mask bit is 1.

Software reads a channel coherently in two steps. First it reads the wrap-count register. That read returns the live wrap count and, at the same clock edge, copies the live counter into a shadow register. The current-value register always returns that shadow, so it holds its old value until the next wrap-count read. Software that wants a rising time base inverts the value it reads.

Top module: `tmr_bank`

## Requirements
- R1: After reset the global enable, every local enable, mask, status bit, counter, wrap count and shadow is 0, every start (reload) register reads 0xFFFFFFFF and every irq_o bit is 0.
- R2: The global control register is at byte offset 0x00, with the enable in bit 0, and the revision register is at 0x10. Channel n (0-based) uses the base 0x20*(n+1). From that base, config (enable in bit 0) is at +0x0, reload at +0x4, current value at +0x8, wrap count at +0xC, status (bit 0) at +0x10, clear at +0x14 and mask (bit 0) at +0x18. Unaligned, unlisted and out-of-range offsets read as 0.
- R3: A channel's counter decreases by one on each clock edge when the global enable and its local enable are both 1. Otherwise it holds its value.
- R4: A write that sets the config enable bit of a stopped channel loads the counter from the reload register at that edge. Counting starts on the following edge.
- R5: A running counter at 0 reloads from the reload register on the next edge. At the same edge its wrap count increases by one and its status bit is set.
- R6: A read of the wrap-count register returns the live wrap count and latches the live counter into the shadow at that edge. Reads of the current-value register return the shadow, which does not change otherwise.
- R7: A write with bit 0 = 1 to the clear register clears the status bit. A write with bit 0 = 0 leaves it set. A wrap in the same cycle as a clear wins, so the bit stays set.
- R8: irq_o[n] is 1 exactly when channel n's status bit and mask bit are both 1.
- R9: Writes to the revision, current-value, wrap-count and status registers change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one counter tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, valid combinationally during a read cycle |
| irq_o | output | NCH (4) | Per-channel interrupt, status AND mask |

## Verification
The properties assume at most one register access per cycle and bus inputs that are always at defined levels after reset. They also assume a counter tick on every clock, with no stall or gap. The bench keeps to this by driving every bus field to a known value one step after each rising edge, holding each access for exactly one cycle and never driving X. Each channel is reconfigured only while it is stopped, so each expected count follows from cycle counting alone.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Register select inside one channel window, taken from address bits [4:2].
  typedef enum logic [2:0] {
    CR_CFG  = 3'd0,
    CR_RLD  = 3'd1,
    CR_CUR  = 3'd2,
    CR_WRAP = 3'd3,
    CR_STAT = 3'd4,
    CR_CLR  = 3'd5,
    CR_MASK = 3'd6,
    CR_NONE = 3'd7
  } chan_reg_e;

  localparam int WIN_LG      = 5;       // 32-byte window per channel
  localparam int GLB_CTRL_LO = 5'h00;
  localparam int GLB_REV_LO  = 5'h10;
endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec import tmr_pkg::*; #(
  parameter int NCH = 4,
  parameter int AW  = 8
) (
  input  logic           bus_en,
  input  logic [AW-1:0]  addr,
  output logic           ctrl_hit,
  output logic           rev_hit,
  output logic [NCH-1:0] chan_hit,
  output chan_reg_e      sel
);
  localparam int IW = AW - WIN_LG;

  logic [IW-1:0] win_idx;
  logic          aligned;

  assign win_idx  = addr[AW-1:WIN_LG];
  assign aligned  = (addr[1:0] == 2'b00);
  assign sel      = chan_reg_e'(addr[4:2]);
  assign ctrl_hit = bus_en && (win_idx == '0) && (addr[WIN_LG-1:0] == WIN_LG'(GLB_CTRL_LO));
  assign rev_hit  = bus_en && (win_idx == '0) && (addr[WIN_LG-1:0] == WIN_LG'(GLB_REV_LO));

  for (genvar g = 0; g < NCH; g++) begin : g_hit
    assign chan_hit[g] = bus_en && aligned && (win_idx == IW'(g + 1)) && (sel != CR_NONE);
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan import tmr_pkg::*; #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_on,
  input  logic          acc_wr,
  input  logic          acc_rd,
  input  chan_reg_e     sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] rld_o,
  output logic          run_o,
  output logic          stat_o,
  output logic          mask_o,
  output logic          load_o
);
  logic          run_q, run_d;
  logic          stat_q, stat_d;
  logic          mask_q, mask_d;
  logic [DW-1:0] rld_q, rld_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] wrp_q, wrp_d;
  logic [DW-1:0] shd_q, shd_d;

  logic wr_cfg, wr_rld, wr_clr, wr_mask, snap, tick, wrap, load;

  always_comb begin
    wr_cfg  = acc_wr && (sel == CR_CFG);
    wr_rld  = acc_wr && (sel == CR_RLD);
    wr_clr  = acc_wr && (sel == CR_CLR) && wdata[0];
    wr_mask = acc_wr && (sel == CR_MASK);
    snap    = acc_rd && (sel == CR_WRAP);
    tick    = blk_on && run_q;
    wrap    = tick && (cnt_q == '0);
    load    = wr_cfg && wdata[0] && !run_q;

    run_d  = wr_cfg  ? wdata[0] : run_q;
    mask_d = wr_mask ? wdata[0] : mask_q;
    rld_d  = wr_rld  ? wdata    : rld_q;

    if (load || wrap)  cnt_d = rld_q;
    else if (tick)     cnt_d = cnt_q - 1'b1;
    else               cnt_d = cnt_q;

    wrp_d = wrap ? wrp_q + 1'b1 : wrp_q;

    if (wrap)        stat_d = 1'b1;
    else if (wr_clr) stat_d = 1'b0;
    else             stat_d = stat_q;

    shd_d = snap ? cnt_q : shd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      stat_q <= 1'b0;
      mask_q <= 1'b0;
      rld_q  <= '1;
      cnt_q  <= '0;
      wrp_q  <= '0;
      shd_q  <= '0;
    end else begin
      run_q  <= run_d;
      stat_q <= stat_d;
      mask_q <= mask_d;
      rld_q  <= rld_d;
      cnt_q  <= cnt_d;
      wrp_q  <= wrp_d;
      shd_q  <= shd_d;
    end
  end

  always_comb begin
    unique case (sel)
      CR_CFG:  rdata = {{(DW-1){1'b0}}, run_q};
      CR_RLD:  rdata = rld_q;
      CR_CUR:  rdata = shd_q;
      CR_WRAP: rdata = wrp_q;
      CR_STAT: rdata = {{(DW-1){1'b0}}, stat_q};
      CR_MASK: rdata = {{(DW-1){1'b0}}, mask_q};
      default: rdata = '0;
    endcase
  end

  assign irq    = stat_q & mask_q;
  assign cnt_o  = cnt_q;
  assign rld_o  = rld_q;
  assign run_o  = run_q;
  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign load_o = load;
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank import tmr_pkg::*; #(
  parameter int          NCH    = 4,
  parameter int          DW     = 32,
  parameter logic [31:0] REV_ID = 32'h0002_0100,
  localparam int         AW     = $clog2(32 * (NCH + 1))
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_en,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] irq_o
);
  // Reset: asserts at once, releases two edges after rst_n rises.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic           ctrl_hit, rev_hit;
  logic [NCH-1:0] chan_hit;
  chan_reg_e      sel;

  tmr_addr_dec #(.NCH(NCH), .AW(AW)) dec_i (
    .bus_en   (bus_en),
    .addr     (bus_addr),
    .ctrl_hit (ctrl_hit),
    .rev_hit  (rev_hit),
    .chan_hit (chan_hit),
    .sel      (sel)
  );

  logic blk_q, blk_d;

  always_comb blk_d = (bus_wr && ctrl_hit) ? bus_wdata[0] : blk_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) blk_q <= 1'b0;
    else            blk_q <= blk_d;
  end

  logic [NCH-1:0][DW-1:0] ch_rdata, ch_cnt, ch_rld;
  logic [NCH-1:0]         ch_run, ch_stat, ch_mask, ch_load;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr_chan #(.DW(DW)) ch_i (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .blk_on (blk_q),
      .acc_wr (chan_hit[g] && bus_wr),
      .acc_rd (chan_hit[g] && !bus_wr),
      .sel    (sel),
      .wdata  (bus_wdata),
      .rdata  (ch_rdata[g]),
      .irq    (irq_o[g]),
      .cnt_o  (ch_cnt[g]),
      .rld_o  (ch_rld[g]),
      .run_o  (ch_run[g]),
      .stat_o (ch_stat[g]),
      .mask_o (ch_mask[g]),
      .load_o (ch_load[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (!bus_wr) begin
      if (ctrl_hit) bus_rdata = {{(DW-1){1'b0}}, blk_q};
      if (rev_hit)  bus_rdata = DW'(REV_ID);
      for (int i = 0; i < NCH; i++) begin
        if (chan_hit[i]) bus_rdata = ch_rdata[i];
      end
    end
  end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_en,
  input logic                   bus_wr,
  input logic [AW-1:0]          bus_addr,
  input logic [DW-1:0]          bus_wdata,
  input logic [NCH-1:0]         irq_o,
  input logic                   blk_q,
  input logic [NCH-1:0][DW-1:0] ch_cnt,
  input logic [NCH-1:0][DW-1:0] ch_rld,
  input logic [NCH-1:0]         ch_run,
  input logic [NCH-1:0]         ch_stat,
  input logic [NCH-1:0]         ch_mask,
  input logic [NCH-1:0]         ch_load
);
  for (genvar g = 0; g < NCH; g++) begin : g_p
    logic clr_wr, live, at_zero;
    assign clr_wr  = bus_en && bus_wr && bus_wdata[0] && (bus_addr == AW'(32 * (g + 1) + 'h14));
    assign live    = blk_q && ch_run[g];
    assign at_zero = live && (ch_cnt[g] == '0);

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!live && !ch_load[g]) |=> $stable(ch_cnt[g]));
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (live && ch_cnt[g] != '0) |=> (ch_cnt[g] == $past(ch_cnt[g]) - 1'b1));
    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ch_load[g] |=> (ch_run[g] && ch_cnt[g] == $past(ch_rld[g])));
    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      at_zero |=> (ch_stat[g] && ch_cnt[g] == $past(ch_rld[g])));
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !at_zero) |=> !ch_stat[g]);
    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o[g]) |-> (ch_mask[g] && ch_stat[g]));
  end
endmodule

bind tmr_bank tmr_bank_chk #(.NCH(NCH), .DW(DW), .AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .bus_en    (bus_en),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_o     (irq_o),
  .blk_q     (blk_q),
  .ch_cnt    (ch_cnt),
  .ch_rld    (ch_rld),
  .ch_run    (ch_run),
  .ch_stat   (ch_stat),
  .ch_mask   (ch_mask),
  .ch_load   (ch_load)
);

// File: tb/tmr_bank_tb_top.sv
`timescale 1ns/1ps
module tmr_bank_tb_top;
  localparam logic [31:0] REV = 32'h0002_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_o;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  tmr_bank #(.NCH(4), .DW(32), .REV_ID(REV)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Each access occupies exactly one cycle; inputs change 1 ns after a rising edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk); d = bus_rdata;
    @(posedge clk); #1;
    bus_en = 1'b0;
  endtask

  task automatic idle(input int n);
    bus_en = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 irq", {28'd0, irq_o}, 32'd0);
    rd(8'h00, v); chk("R1 global enable", v, 32'd0);
    rd(8'h24, v); chk("R1 reload ch0", v, 32'hFFFF_FFFF);
    rd(8'h98, v); chk("R1 mask ch3", v, 32'd0);
    rd(8'h50, v); chk("R1 status ch1", v, 32'd0);
    rd(8'h6C, v); chk("R1 wrap count ch2", v, 32'd0);
    rd(8'h48, v); chk("R1 shadow ch1", v, 32'd0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    rd(8'h10, v); chk("R2 revision", v, REV);
    rd(8'h14, v); chk("R2 unmapped 0x14", v, 32'd0);
    rd(8'h3C, v); chk("R2 unmapped 0x3C", v, 32'd0);
    rd(8'hA0, v); chk("R2 out of range 0xA0", v, 32'd0);
    rd(8'h25, v); chk("R2 unaligned 0x25", v, 32'd0);
  endtask

  // ch3 enabled while the global enable is off: loaded but frozen.
  task automatic t_gate;
    logic [31:0] v;
    wr(8'h84, 32'd50);
    wr(8'h80, 32'd1);
    idle(10);
    rd(8'h8C, v); chk("R3 wrap count gated", v, 32'd0);
    rd(8'h88, v); chk("R3 gated hold (R4 load)", v, 32'd50);
    wr(8'h00, 32'd1);
    rd(8'h00, v); chk("R2 global enable readback", v, 32'd1);
  endtask

  task automatic t_count;
    logic [31:0] v;
    wr(8'h24, 32'd100);
    wr(8'h20, 32'd1);               // load 100 at this edge
    rd(8'h2C, v);                   // snapshot of 100
    rd(8'h28, v); chk("R4 first value after enable", v, 32'd100);
    idle(5);                        // live count 93 after these edges
    rd(8'h2C, v); chk("R6 wrap count live", v, 32'd0);
    rd(8'h28, v); chk("R3 R6 count after 7 edges", v, 32'd93);
    idle(3);
    rd(8'h28, v); chk("R6 stale without snapshot", v, 32'd93);
  endtask

  task automatic t_readonly;
    logic [31:0] v;
    wr(8'h10, 32'hDEAD_BEEF);
    rd(8'h10, v); chk("R9 revision write ignored", v, REV);
    wr(8'h28, 32'd5);
    rd(8'h28, v); chk("R9 current write ignored", v, 32'd93);
    wr(8'h2C, 32'd7);
    rd(8'h2C, v); chk("R9 wrap count write ignored", v, 32'd0);
    wr(8'h30, 32'd1);
    rd(8'h30, v); chk("R9 status write ignored", v, 32'd0);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    wr(8'h44, 32'd3);
    wr(8'h58, 32'd1);
    wr(8'h40, 32'd1);               // count 3
    idle(4);                        // 2,1,0, then wrap to 3
    chk("R8 irq raised", {31'd0, irq_o[1]}, 32'd1);
    rd(8'h50, v); chk("R5 status set on wrap", v, 32'd1);     // count 2
    wr(8'h40, 32'd0);               // counts to 1, then stops
    rd(8'h4C, v); chk("R5 wrap count", v, 32'd1);
    rd(8'h48, v); chk("R5 reloaded then counted", v, 32'd1);
    idle(3);
    rd(8'h4C, v);
    rd(8'h48, v); chk("R3 stopped channel holds", v, 32'd1);
    wr(8'h54, 32'd0);
    rd(8'h50, v); chk("R7 clear with bit0=0 ignored", v, 32'd1);
    wr(8'h54, 32'd1);
    rd(8'h50, v); chk("R7 clear", v, 32'd0);
    chk("R8 irq dropped", {31'd0, irq_o[1]}, 32'd0);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(8'h64, 32'd1);
    wr(8'h60, 32'd1);               // 1, 0, wrap
    idle(3);
    chk("R8 masked irq low", {31'd0, irq_o[2]}, 32'd0);
    rd(8'h70, v); chk("R8 masked status still set", v, 32'd1);
    wr(8'h78, 32'd1);
    chk("R8 unmasked irq high", {31'd0, irq_o[2]}, 32'd1);
    rd(8'h78, v); chk("R2 mask readback", v, 32'd1);
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired got=%h exp=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4);
    t_reset;
    t_map;
    t_gate;
    t_count;
    t_readonly;
    t_wrap;
    t_mask;
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule